// File: doc/BRIEF.md
# Stepped-Frequency Sine Sweep Generator

This block drives a 14-bit digital-to-analog converter with a sine wave whose frequency climbs in discrete steps. It starts at a programmable frequency and adds a fixed increment at each step. The frequency never passes a programmable upper limit. Each step is held for an equal dwell, and the dwells together fill a programmable total sweep time. A 32-bit phase accumulator advances by a tuning word on every clock. The top 10 bits of the accumulator address a 1024-entry full-cycle sine table, which is built at elaboration time in on-chip memory.

Software writes the four sweep settings through a load strobe and then pulses a start input. The block first runs a short setup phase. In that phase a shared sequential divider works out the number of frequency points and then the dwell per point. The block then steps through the points. It reports each change of frequency with a strobe and a point index, and it raises a done flag once the dwell of the final point has expired.

Top module: `sweepDdsTop`

## Requirements
- R1: After reset the sample output is 8192, the index is 0, and the strobe and the done flag are low. The sweep settings reset to a start of 1000 Hz, a stop of 1000000 Hz, a step of 1000 Hz and a sweep time of 40000000 clock cycles (1 s at 40 MHz).
- R2: A high `cfgLoad` copies the four setting inputs into the sweep settings when no sweep is in progress. While setup or stepping is in progress, `cfgLoad` is ignored.
- R3: The frequency of point k is start + k*step. A point that would exceed the stop value is clamped to stop, and that point is the last one. The number of points is ceil((stop-start)/step)+1. A zero step, or a stop at or below start, gives a single point at the start frequency.
- R4: The tuning word of frequency f is floor(f*K/65536) with K = floor(2^48/40000000). The 32-bit phase accumulator adds the tuning word once per clock. It is cleared at the first point of each sweep and continues without a jump across later steps.
- R5: The table entry at address a (accumulator bits 31..22) is floor(8192 + 8191*sin(2*pi*a/1024) + 0.5). The sample output is registered one clock after the accumulator value it comes from.
- R6: The dwell is max(1, floor(T/N)) clock cycles, where T is the sweep time and N is the number of points. Consecutive step strobes are exactly one dwell apart.
- R7: `stepStrobe` is high for one cycle each time a new frequency takes effect. `freqIdx` shows that point's index from that same cycle, counting 0 to N-1, and it holds its value between strobes.
- R8: `sweepDone` rises one dwell after the last strobe. At that moment the tuning word is set to zero, so the sample output freezes. The flag stays high until a new start is accepted, and the accepted start clears it on the next cycle.
- R9: A `startPulse` that arrives during setup or stepping is ignored, and the sweep in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; tuning words assume 40 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Copies the setting inputs into the sweep settings |
| cfgStartHz | input | 24 | First frequency in Hz |
| cfgStopHz | input | 24 | Upper frequency limit in Hz |
| cfgStepHz | input | 24 | Frequency increment in Hz |
| cfgSweepCyc | input | 32 | Total sweep time in clock cycles |
| startPulse | input | 1 | Begins a sweep when idle or finished |
| dacWord | output | 14 | Offset-binary sine sample |
| freqIdx | output | 24 | Index of the current frequency point |
| stepStrobe | output | 1 | One-cycle pulse at each frequency change |
| sweepDone | output | 1 | High once the final dwell has elapsed |

## Verification
Assertions check, on every cycle, the local invariants. The index advances by exactly one at each later strobe and stays still between strobes. The done flag and the strobe are never high together, and done rises only at the last index. A stepped frequency never exceeds the stop value. The accumulator clears at the first point, the tuning word is zero after the sweep ends, and settings and start requests are ignored while a sweep runs. Only the bench scenarios can confirm the end-to-end numbers. These are the dwell derived from the sweep time, the point count with clamping, the single-point and one-cycle-dwell edge cases, and the exact sample sequence. The bench checks the samples against a phase model that it builds from the tuning and table formulas.

// File: rtl/sweep_pkg.sv
package sweepPkg;

  // Strobes from the sequencer to the sample datapath
  typedef struct packed {
    logic loadFirst;  // take the start frequency, clear the phase
    logic loadNext;   // advance to the next (clamped) frequency
    logic halt;       // sweep finished: zero the tuning word
  } sweepCtrlT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIVPTS,
    ST_DIVDWELL,
    ST_RUN,
    ST_DONE
  } sweepStateT;

endpackage

// File: rtl/sweep_divider.sv
module sweepDivider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    remR;
  logic [W-1:0]  quoR;
  logic [W-1:0]  denR;
  logic [W-1:0]  dvdR;
  logic [CW-1:0] cntR;
  logic          busyR;
  logic          doneR;

  logic [W:0] shifted;
  logic       fits;

  assign shifted = {remR[W-1:0], quoR[W-1]};
  assign fits    = shifted >= {1'b0, denR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      quoR  <= '0;
      denR  <= '0;
      dvdR  <= '0;
      cntR  <= '0;
      busyR <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (go) begin
        remR  <= '0;
        quoR  <= dividend;
        dvdR  <= dividend;
        denR  <= divisor;
        cntR  <= CW'(W);
        busyR <= 1'b1;
      end else if (busyR) begin
        remR <= fits ? (shifted - {1'b0, denR}) : shifted;
        quoR <= {quoR[W-2:0], fits};
        cntR <= cntR - CW'(1);
        if (cntR == CW'(1)) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign done     = doneR;
  assign quotient = quoR;

  // R6 (dwell and point count rest on a correct floor division)
  quotient_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneR && denR != '0) |->
      (({{W{1'b0}}, quoR} * {{W{1'b0}}, denR}) <= {{W{1'b0}}, dvdR}) &&
      (remR < {1'b0, denR}));

endmodule

// File: rtl/sweep_control.sv
module sweepControl
  import sweepPkg::*;
#(
  parameter int FREQ_W = 24,
  parameter int TIME_W = 32,
  parameter int IDX_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [FREQ_W-1:0] spanHz,
  input  logic [FREQ_W-1:0] stepHz,
  input  logic [TIME_W-1:0] sweepCyc,
  input  logic              divDone,
  input  logic [TIME_W-1:0] divQuo,
  output logic              divGo,
  output logic [TIME_W-1:0] divA,
  output logic [TIME_W-1:0] divB,
  output sweepCtrlT         ctrl,
  output logic              busy,
  output logic              stepStrobe,
  output logic              sweepDone,
  output logic [IDX_W-1:0]  freqIdx
);
  sweepStateT        stateR;
  logic [IDX_W-1:0]  lastIdxR;
  logic [IDX_W-1:0]  idxR;
  logic [TIME_W-1:0] dwellR;
  logic [TIME_W-1:0] cntR;
  logic              firstR;
  logic              strobeR;
  logic              doneR;

  // Decisions taken this cycle
  always_comb begin
    ctrl  = '0;
    divGo = 1'b0;
    divA  = '0;
    divB  = TIME_W'(1);
    unique case (stateR)
      ST_IDLE, ST_DONE: begin
        if (startPulse) begin
          divGo = 1'b1;
          if (stepHz != '0) begin
            // ceil(span/step) = floor((span+step-1)/step)
            divA = TIME_W'({1'b0, spanHz} + {1'b0, stepHz} - (FREQ_W + 1)'(1));
            divB = TIME_W'(stepHz);
          end
        end
      end
      ST_DIVPTS: begin
        if (divDone) begin
          divGo = 1'b1;
          divA  = sweepCyc;
          divB  = divQuo + TIME_W'(1);
        end
      end
      ST_RUN: begin
        if (cntR == '0) begin
          if (firstR)                ctrl.loadFirst = 1'b1;
          else if (idxR == lastIdxR) ctrl.halt      = 1'b1;
          else                       ctrl.loadNext  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR   <= ST_IDLE;
      lastIdxR <= '0;
      idxR     <= '0;
      dwellR   <= TIME_W'(1);
      cntR     <= '0;
      firstR   <= 1'b0;
      strobeR  <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      strobeR <= ctrl.loadFirst | ctrl.loadNext;
      unique case (stateR)
        ST_IDLE, ST_DONE: begin
          if (startPulse) begin
            stateR <= ST_DIVPTS;
            doneR  <= 1'b0;
          end
        end
        ST_DIVPTS: begin
          if (divDone) begin
            lastIdxR <= IDX_W'(divQuo);
            stateR   <= ST_DIVDWELL;
          end
        end
        ST_DIVDWELL: begin
          if (divDone) begin
            dwellR <= (divQuo == '0) ? TIME_W'(1) : divQuo;
            cntR   <= '0;
            firstR <= 1'b1;
            stateR <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cntR == '0) begin
            if (ctrl.loadFirst) begin
              idxR   <= '0;
              cntR   <= dwellR - TIME_W'(1);
              firstR <= 1'b0;
            end else if (ctrl.halt) begin
              doneR  <= 1'b1;
              stateR <= ST_DONE;
            end else begin
              idxR <= idxR + IDX_W'(1);
              cntR <= dwellR - TIME_W'(1);
            end
          end else begin
            cntR <= cntR - TIME_W'(1);
          end
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (stateR == ST_DIVPTS) || (stateR == ST_DIVDWELL) || (stateR == ST_RUN);
  assign stepStrobe = strobeR;
  assign sweepDone  = doneR;
  assign freqIdx    = idxR;

  // R7
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobeR && idxR != '0) |-> (idxR == $past(idxR) + IDX_W'(1)));

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeR |-> $stable(idxR));

  // R8
  done_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> !strobeR);

  // R8
  done_at_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneR) |-> (idxR == lastIdxR));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_RUN && startPulse) |=> (stateR != ST_DIVPTS));

endmodule

// File: rtl/sweep_datapath.sv
module sweepDatapath
  import sweepPkg::*;
#(
  parameter int CLK_HZ  = 40_000_000,
  parameter int FREQ_W  = 24,
  parameter int ACC_W   = 32,
  parameter int ADDR_W  = 10,
  parameter int DAC_W   = 14,
  parameter int FRAC_SH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sweepCtrlT         ctrl,
  input  logic [FREQ_W-1:0] startHz,
  input  logic [FREQ_W-1:0] stopHz,
  input  logic [FREQ_W-1:0] stepHz,
  output logic [DAC_W-1:0]  dacWord
);
  localparam int          DEPTH = 1 << ADDR_W;
  localparam int          MID   = 1 << (DAC_W - 1);
  localparam int          PW    = ACC_W + FRAC_SH;
  localparam logic [63:0] KMUL  = (64'd1 << PW) / 64'(CLK_HZ);

  // Full-cycle sine table, built at elaboration
  logic [DAC_W-1:0] romW [DEPTH];
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    localparam real ANG = 6.283185307179586 * real'(gi) / real'(DEPTH);
    localparam int  VAL = $rtoi(real'(MID) + real'(MID - 1) * $sin(ANG) + 0.5);
    assign romW[gi] = DAC_W'(VAL);
  end

  logic [FREQ_W-1:0] freqR;
  logic [FREQ_W-1:0] nextFreq;
  logic [FREQ_W:0]   sumHz;
  logic [PW-1:0]     prod;
  logic [ACC_W-1:0]  incNext;
  logic [ACC_W-1:0]  incR;
  logic [ACC_W-1:0]  accR;
  logic [DAC_W-1:0]  dacR;

  assign sumHz = {1'b0, freqR} + {1'b0, stepHz};

  always_comb begin
    if (ctrl.loadFirst)              nextFreq = startHz;
    else if (sumHz >= {1'b0, stopHz}) nextFreq = stopHz;
    else                              nextFreq = sumHz[FREQ_W-1:0];
  end

  assign prod    = PW'(nextFreq) * PW'(KMUL);
  assign incNext = ACC_W'(prod >> FRAC_SH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqR <= '0;
      incR  <= '0;
      accR  <= '0;
      dacR  <= DAC_W'(MID);
    end else begin
      if (ctrl.loadFirst || ctrl.loadNext) begin
        freqR <= nextFreq;
        incR  <= incNext;
      end else if (ctrl.halt) begin
        incR <= '0;
      end
      accR <= ctrl.loadFirst ? '0 : (accR + incR);
      dacR <= romW[accR[ACC_W-1 -: ADDR_W]];
    end
  end

  assign dacWord = dacR;

  // R3
  clamp_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadNext |=> (freqR <= stopHz));

  // R4
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadFirst |=> (accR == '0));

  // R8
  halt_zero_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.halt |=> (incR == '0));

endmodule

// File: rtl/sweep_dds_top.sv
module sweepDdsTop
  import sweepPkg::*;
#(
  parameter int CLK_HZ        = 40_000_000,
  parameter int FREQ_W        = 24,
  parameter int TIME_W        = 32,
  parameter int ACC_W         = 32,
  parameter int ADDR_W        = 10,
  parameter int DAC_W         = 14,
  parameter int DEF_START_HZ  = 1_000,
  parameter int DEF_STOP_HZ   = 1_000_000,
  parameter int DEF_STEP_HZ   = 1_000,
  parameter int DEF_SWEEP_CYC = CLK_HZ
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [FREQ_W-1:0] cfgStartHz,
  input  logic [FREQ_W-1:0] cfgStopHz,
  input  logic [FREQ_W-1:0] cfgStepHz,
  input  logic [TIME_W-1:0] cfgSweepCyc,
  input  logic              startPulse,
  output logic [DAC_W-1:0]  dacWord,
  output logic [FREQ_W-1:0] freqIdx,
  output logic              stepStrobe,
  output logic              sweepDone
);
  localparam int IDX_W = FREQ_W;

  logic [FREQ_W-1:0] startR, stopR, stepR;
  logic [TIME_W-1:0] sweepR;
  logic [FREQ_W-1:0] spanHz;
  logic              busy;
  sweepCtrlT         ctrl;
  logic              divGo, divDone;
  logic [TIME_W-1:0] divA, divB, divQuo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR <= FREQ_W'(DEF_START_HZ);
      stopR  <= FREQ_W'(DEF_STOP_HZ);
      stepR  <= FREQ_W'(DEF_STEP_HZ);
      sweepR <= TIME_W'(DEF_SWEEP_CYC);
    end else if (cfgLoad && !busy) begin
      startR <= cfgStartHz;
      stopR  <= cfgStopHz;
      stepR  <= cfgStepHz;
      sweepR <= cfgSweepCyc;
    end
  end

  assign spanHz = (stopR >= startR) ? (stopR - startR) : '0;

  sweepDivider #(.W(TIME_W)) div_i (
    .clk      (clk),
    .rstN     (rstN),
    .go       (divGo),
    .dividend (divA),
    .divisor  (divB),
    .done     (divDone),
    .quotient (divQuo)
  );

  sweepControl #(
    .FREQ_W (FREQ_W),
    .TIME_W (TIME_W),
    .IDX_W  (IDX_W)
  ) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .spanHz     (spanHz),
    .stepHz     (stepR),
    .sweepCyc   (sweepR),
    .divDone    (divDone),
    .divQuo     (divQuo),
    .divGo      (divGo),
    .divA       (divA),
    .divB       (divB),
    .ctrl       (ctrl),
    .busy       (busy),
    .stepStrobe (stepStrobe),
    .sweepDone  (sweepDone),
    .freqIdx    (freqIdx)
  );

  sweepDatapath #(
    .CLK_HZ (CLK_HZ),
    .FREQ_W (FREQ_W),
    .ACC_W  (ACC_W),
    .ADDR_W (ADDR_W),
    .DAC_W  (DAC_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .startHz (startR),
    .stopHz  (stopR),
    .stepHz  (stepR),
    .dacWord (dacWord)
  );

  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgLoad) |=> ($stable(startR) && $stable(stopR) && $stable(stepR) && $stable(sweepR)));

endmodule

// File: tb/sweep_dds_tb.sv
module sweepDdsTop_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [23:0] cfgStartHz = '0;
  logic [23:0] cfgStopHz = '0;
  logic [23:0] cfgStepHz = '0;
  logic [31:0] cfgSweepCyc = '0;
  logic        startPulse = 1'b0;
  logic [13:0] dacWord;
  logic [23:0] freqIdx;
  logic        stepStrobe;
  logic        sweepDone;

  always #10 clk = ~clk;

  sweepDdsTop dut_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgStartHz(cfgStartHz),
    .cfgStopHz(cfgStopHz), .cfgStepHz(cfgStepHz), .cfgSweepCyc(cfgSweepCyc),
    .startPulse(startPulse), .dacWord(dacWord), .freqIdx(freqIdx),
    .stepStrobe(stepStrobe), .sweepDone(sweepDone)
  );

  localparam longint KM = (64'd1 << 48) / 40000000;

  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  longint aStart, aStop, aStep, aT;
  logic [31:0] accM = '0;
  logic [31:0] incM = '0;
  logic        prevDone = 1'b0;
  bit          modelOn = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R5 table formula
  function automatic int sineOf(int a);
    return $rtoi(8192.0 + 8191.0 * $sin(6.283185307179586 * real'(a) / 1024.0) + 0.5);
  endfunction

  // R3 and R4: frequency of a point and its tuning word
  function automatic logic [31:0] incOf(int idx);
    longint f = aStart + longint'(idx) * aStep;
    if (idx > 0 && f > aStop) f = aStop;
    return 32'((f * KM) >> 16);
  endfunction

  function automatic int expPoints();
    if (aStep == 0 || aStop <= aStart) return 1;
    return int'((aStop - aStart + aStep - 1) / aStep + 1);
  endfunction

  function automatic longint expDwell(int n);
    longint q = aT / n;
    return (q == 0) ? 1 : q;
  endfunction

  // Sample after the edge and step the phase model
  task automatic tick();
    @(posedge clk);
    #2;
    cyc++;
    if (modelOn) begin
      chk("R4 R5 sample", dacWord, sineOf(int'(accM[31:22])));
      if (stepStrobe && freqIdx == 0) accM = '0;
      else accM = accM + incM;
      if (stepStrobe) incM = incOf(int'(freqIdx));
      else if (sweepDone && !prevDone) incM = '0;
      prevDone = sweepDone;
    end
  endtask

  task automatic doReset();
    modelOn = 0;
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    accM = '0; incM = '0; prevDone = 1'b0;
    modelOn = 1;
  endtask

  task automatic loadCfg(longint s, longint p, longint st, longint t);
    cfgLoad = 1'b1;
    cfgStartHz = 24'(s); cfgStopHz = 24'(p); cfgStepHz = 24'(st); cfgSweepCyc = 32'(t);
    tick();
    cfgLoad = 1'b0;
    aStart = s; aStop = p; aStep = st; aT = t;
  endtask

  task automatic waitStrobe(int limit, output bit seen);
    seen = 0;
    for (int w = 0; w < limit; w++) begin
      tick();
      if (stepStrobe) begin
        seen = 1;
        break;
      end
    end
  endtask

  task automatic runSweep(int glitchAt);
    int     n = expPoints();
    longint d = expDwell(n);
    longint last = 0;
    bit     seen;
    startPulse = 1'b1;
    tick();
    startPulse = 1'b0;
    chk("R8 start clears done", sweepDone, 0);
    for (int k = 0; k < n; k++) begin
      waitStrobe(int'(d) + 200, seen);
      chk("R7 strobe present", seen, 1);
      if (!seen) return;
      chk("R7 index", freqIdx, k);
      if (k > 0) chk("R6 dwell spacing", cyc - last, d);
      chk("R8 done low while stepping", sweepDone, 0);
      last = cyc;
      if (k == glitchAt && d > 1) begin
        // R9 and R2: start and settings during a sweep are ignored
        cfgLoad = 1'b1; startPulse = 1'b1;
        cfgStartHz = 24'd3000; cfgStopHz = 24'd3000; cfgStepHz = 24'd7; cfgSweepCyc = 32'd9;
        tick();
        cfgLoad = 1'b0; startPulse = 1'b0;
        chk("R9 no restart strobe", stepStrobe, 0);
      end
    end
    for (int w = 0; w < int'(d) + 10; w++) begin
      tick();
      if (stepStrobe) chk("R3 no extra point", 1, 0);
      if (sweepDone) break;
    end
    chk("R8 done raised", sweepDone, 1);
    chk("R8 done latency", cyc - last, d);
    repeat (4) begin
      tick();
      chk("R8 done holds", sweepDone, 1);
      chk("R8 no strobe after done", stepStrobe, 0);
    end
  endtask

  initial begin
    bit seen;
    longint first;
    int unsigned seedInit = $urandom(32'd20240611);
    aStart = 1000; aStop = 1000000; aStep = 1000; aT = 40000000;
    doReset();
    // R1 reset state
    chk("R1 reset sample", dacWord, 8192);
    chk("R1 reset index", freqIdx, 0);
    chk("R1 reset strobe", stepStrobe, 0);
    chk("R1 reset done", sweepDone, 0);

    // R1 default settings: 1000 points, dwell 40000 cycles
    startPulse = 1'b1; tick(); startPulse = 1'b0;
    waitStrobe(300, seen);
    chk("R1 default first strobe", seen, 1);
    chk("R1 default first index", freqIdx, 0);
    first = cyc;
    waitStrobe(40100, seen);
    chk("R1 default second index", freqIdx, 1);
    chk("R1 default dwell", cyc - first, 40000);
    doReset();

    // R3 R6: exact multiple, then R9 R2 mid-sweep start and load
    loadCfg(1000, 5000, 1000, 500);
    runSweep(1);
    runSweep(-1);            // R2: the mid-sweep load had no effect
    // R2: load while idle takes effect; R3 clamp 9000
    loadCfg(2000, 9000, 3000, 90);
    runSweep(-1);
    // R3 clamp with non-multiple stop
    loadCfg(1000, 4500, 1000, 250);
    runSweep(-1);
    // R3 zero step: single point
    loadCfg(5000, 9000, 0, 77);
    runSweep(-1);
    // R3 stop below start: single point
    loadCfg(9000, 4000, 500, 50);
    runSweep(-1);
    // R6 sweep time shorter than point count: dwell 1
    loadCfg(100, 1000, 100, 3);
    runSweep(-1);

    // Random settings
    for (int it = 0; it < 12; it++) begin
      longint s  = longint'($urandom_range(200000, 1));
      longint st = longint'($urandom_range(50000, 1));
      longint sp = longint'($urandom_range(int'(st) * 7, 0));
      longint t  = longint'($urandom_range(400, 1));
      loadCfg(s, s + sp, st, t);
      runSweep((it % 3 == 0) ? 0 : -1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired R7 actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule